// File: doc/BRIEF.md
# Quadrature Multi-Mode Position Counter

This block tracks the position of an incremental encoder. It takes the two quadrature phases A and B and an index pulse. It counts up or down at one, two or four counts per encoder cycle. One of four range behaviours governs what happens at the ends of the count: wrap freely, recycle at a programmed modulus, clamp, or stop until re-armed. The count register, a data register and a latch register all share one byte width, which can be 1, 2, 3 or 4 bytes. Any bits above that width are kept at zero.

A host interface outside this block supplies two mode words, writes the data register and pulses four commands: clear count, load count from data, latch count and clear status. An equality comparator raises a flag that can serve as an interrupt. The index pulse can be set to load, clear or latch the count. A status byte gathers sticky event bits alongside live state.

Top module: `qpc_top`

## Requirements
- R1: While `rst` is high at a clock edge, count, latch, status and compare flag are all zero.
- R2: A, B and index each pass through a two-flop synchroniser; an input change sampled at edge k takes effect on the count at edge k+2. The forward phase order of {A,B} is 00, 10, 11, 01. `mode0_i[1:0]` sets the resolution: 0 counts once per cycle (only the 00/10 transition), 1 counts on every A edge, 2 or 3 counts on every transition. A change of both phases at once is not counted.
- R3: `mode1_i[1:0]` sets the width: code 0 = 4 bytes, 1 = 3, 2 = 2, 3 = 1. Count, data and latch registers are masked to that width at every clock, so bytes above it read zero, and a data write stores only the low bytes.
- R4: Range mode 0 (`mode0_i[3:2]`) wraps. Counting up from all-ones gives zero and sets carry (status bit 0). Counting down from zero gives all-ones and sets borrow (status bit 1).
- R5: Range mode 3 counts modulo data+1. Up at or above data gives zero with carry. Down at zero gives data with borrow.
- R6: Range mode 1 stops at the width limits. A step beyond all-ones or below zero leaves the count unchanged, sets carry or borrow, and sets frozen (status bit 4). Further steps are then ignored until a clear or load.
- R7: Range mode 2 clamps. Up at or above data holds with carry. Down at zero holds with borrow.
- R8: On a rising index edge, `mode0_i[5:4]` picks the action: 0 = none, 1 = load the count from data, 2 = clear the count, 3 = copy the count into the latch. Every rising index edge sets status bit 3.
- R9: Commands act at the next edge. Clear wins over load, and both win over index actions and counting. A load takes the data value from before a write in the same cycle. The latch captures the count from before that edge.
- R10: `cmp_flag` is high one cycle after count equals data, and sets sticky status bit 2.
- R11: With `mode1_i[2]` high, encoder steps change neither the count nor the carry and borrow bits.
- R12: `cmd_clr_status` zeroes status bits 3:0 at the next edge, taking priority over new events. Bit 5 shows the last counted direction (1 = up). Bit 6 is the top bit of the count at the current width. Bit 7 reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enc_a | input | 1 | Encoder phase A (asynchronous) |
| enc_b | input | 1 | Encoder phase B (asynchronous) |
| enc_idx | input | 1 | Encoder index pulse (asynchronous) |
| mode0_i | input | 6 | Resolution [1:0], range mode [3:2], index action [5:4] |
| mode1_i | input | 3 | Width code [1:0], count disable [2] |
| dtr_wr | input | 1 | Write strobe for the data register |
| dtr_wdata | input | 8*NBYTES | Data register write value |
| cmd_clr_cnt | input | 1 | Clear the count |
| cmd_load_cnt | input | 1 | Load count from data register |
| cmd_latch | input | 1 | Copy count into latch register |
| cmd_clr_status | input | 1 | Clear sticky status bits |
| cnt_q | output | 8*NBYTES | Count register |
| latch_q | output | 8*NBYTES | Latch register |
| status_q | output | 8 | Status byte |
| cmp_flag | output | 1 | Count-equals-data flag |

## Verification
The hardest state to reach is the stopped state of range mode 1. A step has to land exactly on a width boundary, after which later steps must be shown to do nothing. The stimulus gets there by narrowing the width to one byte, loading the count to one below all-ones through the data register, and then stepping the encoder past the top. Two other cases need a deliberate input pattern rather than ordinary motion: the ignored double-phase jump, and a data write coinciding with a load.

// File: rtl/qpc_pkg.sv
package qpc_pkg;
  typedef enum logic [1:0] {
    RES_X1  = 2'd0,
    RES_X2  = 2'd1,
    RES_X4  = 2'd2,
    RES_X4B = 2'd3
  } res_e;

  typedef enum logic [1:0] {
    RNG_FREE    = 2'd0,
    RNG_ONESHOT = 2'd1,
    RNG_CLAMP   = 2'd2,
    RNG_MODULO  = 2'd3
  } range_e;

  typedef enum logic [1:0] {
    IDX_OFF   = 2'd0,
    IDX_LOAD  = 2'd1,
    IDX_CLEAR = 2'd2,
    IDX_LATCH = 2'd3
  } idx_act_e;

  typedef struct packed {
    idx_act_e idx;
    range_e   rng;
    res_e     res;
  } mode0_t;

  typedef struct packed {
    logic up;
    logic dn;
  } step_t;
endpackage

// File: rtl/qpc_sync.sv
module qpc_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  genvar g;
  for (g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) stg[g] <= '0;
        else     stg[g] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) stg[g] <= '0;
        else     stg[g] <= stg[g-1];
      end
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/qpc_quad_decode.sv
module qpc_quad_decode
  import qpc_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  a_s,
  input  logic  b_s,
  input  res_e  res,
  output step_t step
);
  logic [1:0] prev_ab;
  logic [1:0] pos_now, pos_prev, delta;
  logic       fwd, bwd, a_edge;

  // phase position: 00->0, 10->1, 11->2, 01->3
  assign pos_now  = {b_s, a_s ^ b_s};
  assign pos_prev = {prev_ab[0], prev_ab[1] ^ prev_ab[0]};
  assign delta    = pos_now - pos_prev;

  always_comb begin
    fwd    = (delta == 2'd1);
    bwd    = (delta == 2'd3);
    a_edge = a_s ^ prev_ab[1];
    case (res)
      RES_X1: begin
        step.up = fwd & a_edge & ~b_s;
        step.dn = bwd & a_edge & ~b_s;
      end
      RES_X2: begin
        step.up = fwd & a_edge;
        step.dn = bwd & a_edge;
      end
      default: begin
        step.up = fwd;
        step.dn = bwd;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) prev_ab <= 2'b00;
    else     prev_ab <= {a_s, b_s};
  end
endmodule

// File: rtl/qpc_count_unit.sv
module qpc_count_unit
  import qpc_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  step_t         step,
  input  logic          count_en,
  input  range_e        rng,
  input  logic [DW-1:0] mask,
  input  logic [DW-1:0] limit,
  input  logic [DW-1:0] load_val,
  input  logic          do_clear,
  input  logic          do_load,
  output logic [DW-1:0] cnt_q,
  output logic          carry_ev,
  output logic          borrow_ev,
  output logic          frozen_q,
  output logic          dir_up_q
);
  logic [DW-1:0] nxt;
  logic          frz_n, dir_n, adv_up, adv_dn;
  logic          at_top, at_zero, at_lim;

  assign adv_up  = count_en & ~frozen_q & step.up;
  assign adv_dn  = count_en & ~frozen_q & step.dn;
  assign at_top  = (cnt_q == mask);
  assign at_zero = (cnt_q == '0);
  assign at_lim  = (cnt_q >= limit);

  always_comb begin
    nxt       = cnt_q;
    frz_n     = frozen_q;
    dir_n     = dir_up_q;
    carry_ev  = 1'b0;
    borrow_ev = 1'b0;
    if (do_clear) begin
      nxt   = '0;
      frz_n = 1'b0;
    end else if (do_load) begin
      nxt   = load_val;
      frz_n = 1'b0;
    end else if (adv_up) begin
      dir_n = 1'b1;
      case (rng)
        RNG_FREE: begin
          carry_ev = at_top;
          nxt      = at_top ? '0 : cnt_q + 1'b1;
        end
        RNG_ONESHOT: begin
          carry_ev = at_top;
          frz_n    = at_top;
          nxt      = at_top ? cnt_q : cnt_q + 1'b1;
        end
        RNG_CLAMP: begin
          carry_ev = at_lim;
          nxt      = at_lim ? cnt_q : cnt_q + 1'b1;
        end
        default: begin
          carry_ev = at_lim;
          nxt      = at_lim ? '0 : cnt_q + 1'b1;
        end
      endcase
    end else if (adv_dn) begin
      dir_n     = 1'b0;
      borrow_ev = at_zero;
      case (rng)
        RNG_FREE:    nxt = at_zero ? mask : cnt_q - 1'b1;
        RNG_ONESHOT: begin
          frz_n = at_zero;
          nxt   = at_zero ? cnt_q : cnt_q - 1'b1;
        end
        RNG_CLAMP:   nxt = at_zero ? cnt_q : cnt_q - 1'b1;
        default:     nxt = at_zero ? limit : cnt_q - 1'b1;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q    <= '0;
      frozen_q <= 1'b0;
      dir_up_q <= 1'b0;
    end else begin
      cnt_q    <= nxt & mask;
      frozen_q <= frz_n;
      dir_up_q <= dir_n;
    end
  end
endmodule

// File: rtl/qpc_top.sv
module qpc_top
  import qpc_pkg::*;
#(
  parameter int NBYTES      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  enc_a,
  input  logic                  enc_b,
  input  logic                  enc_idx,
  input  logic [5:0]            mode0_i,
  input  logic [2:0]            mode1_i,
  input  logic                  dtr_wr,
  input  logic [8*NBYTES-1:0]   dtr_wdata,
  input  logic                  cmd_clr_cnt,
  input  logic                  cmd_load_cnt,
  input  logic                  cmd_latch,
  input  logic                  cmd_clr_status,
  output logic [8*NBYTES-1:0]   cnt_q,
  output logic [8*NBYTES-1:0]   latch_q,
  output logic [7:0]            status_q,
  output logic                  cmp_flag
);
  localparam int DW = 8 * NBYTES;

  mode0_t        m0;
  logic [2:0]    sy;
  logic          idx_prev, idx_rise;
  step_t         step;
  logic [DW-1:0] mask, dtr_q;
  logic          do_clear, do_load, do_latch;
  logic          carry_ev, borrow_ev, frozen, dir_up;
  logic          car_st, bor_st, cmp_st, idx_st, sign;
  logic          eq_now;

  assign m0 = mode0_t'(mode0_i);

  qpc_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({enc_a, enc_b, enc_idx}),
    .q   (sy)
  );

  qpc_quad_decode u_dec (
    .clk  (clk),
    .rst  (rst),
    .a_s  (sy[2]),
    .b_s  (sy[1]),
    .res  (m0.res),
    .step (step)
  );

  always_ff @(posedge clk) begin
    if (rst) idx_prev <= 1'b0;
    else     idx_prev <= sy[0];
  end
  assign idx_rise = sy[0] & ~idx_prev;

  // width mask and sign bit from the width code
  always_comb begin
    int nbytes;
    nbytes = (int'(mode1_i[1:0]) >= NBYTES) ? 1 : NBYTES - int'(mode1_i[1:0]);
    sign   = 1'b0;
    for (int b = 0; b < NBYTES; b++) begin
      mask[8*b +: 8] = (b < nbytes) ? 8'hFF : 8'h00;
      if (b == nbytes - 1) sign = cnt_q[8*b+7];
    end
  end

  assign do_clear = cmd_clr_cnt  | (idx_rise & (m0.idx == IDX_CLEAR));
  assign do_load  = cmd_load_cnt | (idx_rise & (m0.idx == IDX_LOAD));
  assign do_latch = cmd_latch    | (idx_rise & (m0.idx == IDX_LATCH));

  qpc_count_unit #(.DW(DW)) u_cnt (
    .clk       (clk),
    .rst       (rst),
    .step      (step),
    .count_en  (~mode1_i[2]),
    .rng       (m0.rng),
    .mask      (mask),
    .limit     (dtr_q),
    .load_val  (dtr_q),
    .do_clear  (do_clear),
    .do_load   (do_load),
    .cnt_q     (cnt_q),
    .carry_ev  (carry_ev),
    .borrow_ev (borrow_ev),
    .frozen_q  (frozen),
    .dir_up_q  (dir_up)
  );

  assign eq_now = (cnt_q == dtr_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      dtr_q    <= '0;
      latch_q  <= '0;
      cmp_flag <= 1'b0;
      car_st   <= 1'b0;
      bor_st   <= 1'b0;
      cmp_st   <= 1'b0;
      idx_st   <= 1'b0;
    end else begin
      dtr_q    <= dtr_wr ? (dtr_wdata & mask) : (dtr_q & mask);
      latch_q  <= do_latch ? (cnt_q & mask) : (latch_q & mask);
      cmp_flag <= eq_now;
      if (cmd_clr_status) begin
        car_st <= 1'b0;
        bor_st <= 1'b0;
        cmp_st <= 1'b0;
        idx_st <= 1'b0;
      end else begin
        car_st <= car_st | carry_ev;
        bor_st <= bor_st | borrow_ev;
        cmp_st <= cmp_st | eq_now;
        idx_st <= idx_st | idx_rise;
      end
    end
  end

  assign status_q = {1'b0, sign, dir_up, frozen, idx_st, cmp_st, bor_st, car_st};
endmodule

// File: rtl/qpc_checker.sv
module qpc_checker #(
  parameter int NBYTES = 4
) (
  input logic                clk,
  input logic                rst,
  input logic [2:0]          mode1_i,
  input logic                cmd_clr_status,
  input logic [8*NBYTES-1:0] cnt_q,
  input logic [7:0]          status_q,
  input logic                cmp_flag
);
  function automatic logic [8*NBYTES-1:0] wmask(input logic [1:0] code);
    int nb;
    logic [8*NBYTES-1:0] m;
    nb = (int'(code) >= NBYTES) ? 1 : NBYTES - int'(code);
    for (int b = 0; b < NBYTES; b++) m[8*b +: 8] = (b < nb) ? 8'hFF : 8'h00;
    return m;
  endfunction

  // R3
  cnt_width_chk: assert property (@(posedge clk) disable iff (rst)
    $stable(mode1_i[1:0]) |-> ((cnt_q & ~wmask(mode1_i[1:0])) == '0));

  // R6
  frozen_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (status_q[4] && $past(status_q[4])) |->
      (cnt_q == ($past(cnt_q) & wmask($past(mode1_i[1:0])))));

  // R11
  disabled_no_carry_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(status_q[0]) |-> !$past(mode1_i[2]));

  // R4
  carry_borrow_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !($rose(status_q[0]) && $rose(status_q[1])));

  // R12
  status_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $past(cmd_clr_status) |-> (status_q[3:0] == 4'b0000));

  // R10
  cmp_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (cmp_flag && !$past(cmd_clr_status)) |-> status_q[2]);
endmodule

bind qpc_top qpc_checker #(.NBYTES(NBYTES)) u_chk (.*);

// File: tb/qpc_top_test.sv
module qpc_top_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        enc_a = 1'b0, enc_b = 1'b0, enc_idx = 1'b0;
  logic [5:0]  mode0 = '0;
  logic [2:0]  mode1 = '0;
  logic        dtr_wr = 1'b0;
  logic [31:0] dtr_wdata = '0;
  logic        cmd_clr_cnt = 1'b0, cmd_load_cnt = 1'b0, cmd_latch = 1'b0, cmd_clr_status = 1'b0;
  logic [31:0] cnt_q, latch_q;
  logic [7:0]  status_q;
  logic        cmp_flag;

  int checks = 0, errors = 0, ph = 0;
  string cur_req = "R1";
  bit m_valid = 0, done = 0;

  always #4 clk = ~clk;

  qpc_top uut (
    .clk(clk), .rst(rst), .enc_a(enc_a), .enc_b(enc_b), .enc_idx(enc_idx),
    .mode0_i(mode0), .mode1_i(mode1), .dtr_wr(dtr_wr), .dtr_wdata(dtr_wdata),
    .cmd_clr_cnt(cmd_clr_cnt), .cmd_load_cnt(cmd_load_cnt), .cmd_latch(cmd_latch),
    .cmd_clr_status(cmd_clr_status), .cnt_q(cnt_q), .latch_q(latch_q),
    .status_q(status_q), .cmp_flag(cmp_flag)
  );

  // ---------------- reference model ----------------
  bit [31:0] m_cnt, m_dtr, m_out;
  bit        m_frz, m_dir, m_car, m_bor, m_cmps, m_idxs, m_cmp;
  bit [2:0]  h1, h2, h3;

  function automatic bit [31:0] mask_of(input bit [1:0] code);
    case (code)
      2'd0: return 32'hFFFF_FFFF;
      2'd1: return 32'h00FF_FFFF;
      2'd2: return 32'h0000_FFFF;
      default: return 32'h0000_00FF;
    endcase
  endfunction

  function automatic int phase_of(input bit [1:0] ab);
    case (ab)
      2'b00: return 0;
      2'b10: return 1;
      2'b11: return 2;
      default: return 3;
    endcase
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_cnt = 0; m_dtr = 0; m_out = 0; m_frz = 0; m_dir = 0;
      m_car = 0; m_bor = 0; m_cmps = 0; m_idxs = 0; m_cmp = 0;
      h1 = 0; h2 = 0; h3 = 0; m_valid = 1;
    end else begin
      bit [31:0] mk, nc;
      int d;
      bit up, dn, achg, irise, clr, ld, lat, car, bor, nf, nd, eq;
      mk   = mask_of(mode1[1:0]);
      d    = (phase_of(h2[2:1]) - phase_of(h3[2:1]) + 4) % 4;
      achg = h2[2] != h3[2];
      case (mode0[1:0])
        2'd0: begin
          up = (d == 1) && achg && !h2[1] && !h3[1];
          dn = (d == 3) && achg && !h2[1] && !h3[1];
        end
        2'd1: begin up = (d == 1) && achg; dn = (d == 3) && achg; end
        default: begin up = (d == 1); dn = (d == 3); end
      endcase
      irise = h2[0] && !h3[0];
      clr = cmd_clr_cnt  || (irise && mode0[5:4] == 2'd2);
      ld  = cmd_load_cnt || (irise && mode0[5:4] == 2'd1);
      lat = cmd_latch    || (irise && mode0[5:4] == 2'd3);
      nc = m_cnt; nf = m_frz; nd = m_dir; car = 0; bor = 0;
      if (clr) begin nc = 0; nf = 0; end
      else if (ld) begin nc = m_dtr; nf = 0; end
      else if (!mode1[2] && !m_frz && (up || dn)) begin
        nd = up;
        if (up) begin
          case (mode0[3:2])
            2'd0: if (m_cnt == mk) begin nc = 0; car = 1; end else nc = m_cnt + 1;
            2'd1: if (m_cnt == mk) begin car = 1; nf = 1; end else nc = m_cnt + 1;
            2'd2: if (m_cnt >= m_dtr) car = 1; else nc = m_cnt + 1;
            default: if (m_cnt >= m_dtr) begin nc = 0; car = 1; end else nc = m_cnt + 1;
          endcase
        end else begin
          bor = (m_cnt == 0);
          case (mode0[3:2])
            2'd0: nc = bor ? mk : m_cnt - 1;
            2'd1: begin if (bor) nf = 1; else nc = m_cnt - 1; end
            2'd2: nc = bor ? m_cnt : m_cnt - 1;
            default: nc = bor ? m_dtr : m_cnt - 1;
          endcase
        end
      end
      eq = (m_cnt == m_dtr);
      if (lat) m_out = m_cnt;
      m_out = m_out & mk;
      m_dtr = dtr_wr ? (dtr_wdata & mk) : (m_dtr & mk);
      m_cnt = nc & mk; m_frz = nf; m_dir = nd; m_cmp = eq;
      if (cmd_clr_status) begin m_car = 0; m_bor = 0; m_cmps = 0; m_idxs = 0; end
      else begin
        m_car = m_car | car; m_bor = m_bor | bor;
        m_cmps = m_cmps | eq; m_idxs = m_idxs | irise;
      end
      h3 = h2; h2 = h1; h1 = {enc_a, enc_b, enc_idx};
    end
  end

  // per-clock comparison against the model
  always @(posedge clk) begin
    #2;
    if (m_valid && !done) begin
      int nb;
      bit [7:0] est;
      nb  = 4 - int'(mode1[1:0]);
      est = {1'b0, m_cnt[8*nb-1], m_dir, m_frz, m_idxs, m_cmps, m_bor, m_car};
      checks++;
      if (cnt_q !== m_cnt || latch_q !== m_out || status_q !== est || cmp_flag !== m_cmp) begin
        errors++;
        $display("FAIL %s model: cnt %h/%h latch %h/%h status %h/%h cmp %b/%b (actual/expected)",
                 cur_req, cnt_q, m_cnt, latch_q, m_out, status_q, est, cmp_flag, m_cmp);
      end
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic set_ab(input int p);
    case (p & 3)
      0: {enc_a, enc_b} = 2'b00;
      1: {enc_a, enc_b} = 2'b10;
      2: {enc_a, enc_b} = 2'b11;
      default: {enc_a, enc_b} = 2'b01;
    endcase
  endtask

  task automatic quad(input int n, input bit up);
    for (int i = 0; i < n; i++) begin
      ph = up ? ph + 1 : ph + 3;
      set_ab(ph);
      tick(3);
    end
    tick(3);
  endtask

  task automatic set_mode(input bit [1:0] res, input bit [1:0] rng, input bit [1:0] ia,
                          input bit [1:0] wc, input bit dis);
    mode0 = {ia, rng, res};
    mode1 = {dis, wc};
    tick(2);
  endtask

  task automatic cmd(input bit c, input bit l, input bit t, input bit s);
    cmd_clr_cnt = c; cmd_load_cnt = l; cmd_latch = t; cmd_clr_status = s;
    tick(1);
    cmd_clr_cnt = 0; cmd_load_cnt = 0; cmd_latch = 0; cmd_clr_status = 0;
    tick(2);
  endtask

  task automatic wr_dtr(input logic [31:0] v);
    dtr_wr = 1; dtr_wdata = v;
    tick(1);
    dtr_wr = 0;
    tick(2);
  endtask

  task automatic idx_pulse();
    enc_idx = 1; tick(3);
    enc_idx = 0; tick(4);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  // ---------------- directed sequence ----------------
  initial begin
    cur_req = "R1";
    tick(4);
    chk("R1 count", cnt_q, 0);
    chk("R1 status", {24'h0, status_q}, 0);
    chk("R1 latch", latch_q, 0);
    rst = 0;
    tick(2);

    cur_req = "R2";
    set_mode(2'd2, 2'd0, 2'd0, 2'd0, 0);
    quad(8, 1);  chk("R2 x4 up", cnt_q, 8);
    set_mode(2'd1, 2'd0, 2'd0, 2'd0, 0);
    quad(4, 1);  chk("R2 x2 up", cnt_q, 10);
    set_mode(2'd0, 2'd0, 2'd0, 2'd0, 0);
    quad(4, 1);  chk("R2 x1 up", cnt_q, 11);
    set_mode(2'd2, 2'd0, 2'd0, 2'd0, 0);
    quad(3, 0);  chk("R2 x4 down", cnt_q, 8);
    ph = ph + 2; set_ab(ph); tick(6);
    chk("R2 double change ignored", cnt_q, 8);

    cur_req = "R4";
    cmd(1, 0, 0, 1);
    set_mode(2'd2, 2'd0, 2'd0, 2'd3, 0);
    quad(1, 0);  chk("R4 underflow wraps", cnt_q, 32'hFF);
    chk("R4 borrow", {31'h0, status_q[1]}, 1);
    quad(1, 1);  chk("R4 overflow wraps", cnt_q, 0);
    chk("R4 carry", {31'h0, status_q[0]}, 1);
    cur_req = "R12";
    cmd(0, 0, 0, 1);
    tick(1);
    chk("R12 carry/borrow cleared", {30'h0, status_q[1:0]}, 0);

    cur_req = "R3";
    set_mode(2'd2, 2'd0, 2'd0, 2'd2, 0);
    wr_dtr(32'h0001_2345);
    cmd(0, 1, 0, 0); chk("R3 load masked to 2 bytes", cnt_q, 32'h2345);
    cmd(0, 0, 1, 0); chk("R3 latch", latch_q, 32'h2345);
    set_mode(2'd2, 2'd0, 2'd0, 2'd3, 0);
    chk("R3 narrow to 1 byte", cnt_q, 32'h45);
    set_mode(2'd2, 2'd0, 2'd0, 2'd0, 0);
    chk("R3 widen keeps zeros", cnt_q, 32'h45);

    cur_req = "R5";
    set_mode(2'd2, 2'd3, 2'd0, 2'd0, 0);
    wr_dtr(5); cmd(1, 0, 0, 0);
    quad(7, 1);  chk("R5 modulo up", cnt_q, 1);
    quad(3, 0);  chk("R5 modulo down", cnt_q, 4);

    cur_req = "R7";
    set_mode(2'd2, 2'd2, 2'd0, 2'd0, 0);
    wr_dtr(3); cmd(1, 0, 0, 0);
    quad(6, 1);  chk("R7 clamp high", cnt_q, 3);
    quad(5, 0);  chk("R7 clamp low", cnt_q, 0);

    cur_req = "R6";
    set_mode(2'd2, 2'd1, 2'd0, 2'd3, 0);
    wr_dtr(32'hFE); cmd(0, 1, 0, 1);
    quad(3, 1);  chk("R6 stops at top", cnt_q, 32'hFF);
    chk("R6 frozen", {31'h0, status_q[4]}, 1);
    quad(2, 0);  chk("R6 ignores steps while frozen", cnt_q, 32'hFF);
    cmd(1, 0, 0, 0);
    quad(1, 1);  chk("R6 resumes after clear", cnt_q, 1);

    cur_req = "R8";
    set_mode(2'd2, 2'd0, 2'd1, 2'd0, 0);
    wr_dtr(32'h40); cmd(0, 0, 0, 1);
    idx_pulse(); chk("R8 index load", cnt_q, 32'h40);
    chk("R8 index status", {31'h0, status_q[3]}, 1);
    set_mode(2'd2, 2'd0, 2'd3, 2'd0, 0);
    quad(2, 1); idx_pulse(); chk("R8 index latch", latch_q, 32'h42);
    set_mode(2'd2, 2'd0, 2'd2, 2'd0, 0);
    idx_pulse(); chk("R8 index clear", cnt_q, 0);

    cur_req = "R9";
    set_mode(2'd2, 2'd0, 2'd0, 2'd0, 0);
    quad(5, 1); cmd(0, 0, 1, 0); chk("R9 latch command", latch_q, 5);
    cmd(1, 1, 0, 0); chk("R9 clear beats load", cnt_q, 0);
    dtr_wr = 1; dtr_wdata = 32'h99; cmd_load_cnt = 1;
    tick(1);
    dtr_wr = 0; cmd_load_cnt = 0;
    tick(2);
    chk("R9 load uses old data", cnt_q, 32'h40);

    cur_req = "R10";
    wr_dtr(2); cmd(1, 0, 0, 1);
    chk("R10 no match", {31'h0, cmp_flag}, 0);
    quad(2, 1);
    chk("R10 flag", {31'h0, cmp_flag}, 1);
    chk("R10 sticky", {31'h0, status_q[2]}, 1);

    cur_req = "R11";
    set_mode(2'd2, 2'd0, 2'd0, 2'd0, 1);
    quad(4, 1); chk("R11 disabled", cnt_q, 2);
    set_mode(2'd2, 2'd0, 2'd0, 2'd0, 0);

    cur_req = "R12";
    set_mode(2'd2, 2'd0, 2'd0, 2'd3, 0);
    wr_dtr(32'h80); cmd(0, 1, 0, 0);
    chk("R12 sign bit", {31'h0, status_q[6]}, 1);
    cmd(0, 0, 0, 1); tick(2);
    chk("R12 sticky cleared, compare re-armed", {28'h0, status_q[3:0]}, 32'h4);

    tick(5);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule